// File: doc/BRIEF.md
# Dual-Channel Free-Running Compare Timer

The block holds a free-running up-counter, 24 bits wide by default, that advances by one on every clock and wraps from its maximum value back to zero. Two independent compare channels watch the counter. Each channel holds a match value written by a host. When the counter equals that value and the channel is enabled, the channel sets its own sticky interrupt flag and applies a selectable action to its own output pin. The action can set the pin, clear it, toggle it or leave it unchanged. A counter wrap sets a separate overflow flag that drives its own interrupt line.

Software schedules a delayed event by reading the counter, adding an interval, and writing the sum back as a match value. The match is an exact equality test, so a sum that passes the counter's maximum wraps modulo 2^W and still fires after the counter overflows. Each interrupt source has its own output line, so a handler can tell the sources apart without reading status. The register interface is word-addressed with a 3-bit address. Writes take effect at the clock edge. Reads are combinational.

Top module: `tmr_cmp_top`

## Requirements
- R1: While reset is high and after its release, the counter reads 0 at the reset edge, every interrupt line and pin is 0, and the control register (address 1) reads 0.
- R2: The counter at address 0 grows by exactly one per clock, modulo 2^W. A write to address 0 has no effect on it.
- R3: For an enabled channel whose match value (address 3 for channel 0, address 4 for channel 1) is written at edge E as the counter value read before E plus D (D of at least 2), the channel's interrupt line is low after edge E+D-1 and high after edge E+D.
- R4: A channel flag stays set until 1 is written to its bit in the status register (address 2: bit 0 channel 0, bit 1 channel 1, bit 2 overflow). Writing 0 to a bit leaves that bit unchanged. The interrupt lines mirror the flags.
- R5: On a match, the pin applies the 2-bit action of that channel: 0 no change, 1 set, 2 clear, 3 toggle. At address 1, channel i uses bit 3i as its enable and bits 3i+2:3i+1 as its action. Between matches the pin holds its value.
- R6: A disabled channel sets no flag and leaves its pin unchanged when the counter equals its match value.
- R7: A match on one channel leaves the other channel's flag and pin unchanged. Two channels with the same match value both fire on the same edge.
- R8: A match value computed as counter plus interval and wrapped modulo 2^W fires the stated number of cycles later, even when the counter wraps inside the interval.
- R9: The edge on which the counter goes from all ones to zero sets the overflow flag on its own line (irq_ovf). The flag is cleared by writing 1 to status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_cmp | output | 2 | Per-channel compare interrupt lines |
| irq_ovf | output | 1 | Counter overflow interrupt line |
| cmp_pin | output | 2 | Per-channel compare output pins |

## Verification
A table of scheduled events drives the main function. Each entry picks a channel, an enable, a pin action and a delay. The entries walk the pin through set, toggle, clear and no-change actions from both pin levels, so a wrong action encoding shows up as a wrong pin level. A disabled entry separates gating from matching. Every entry is sampled one cycle before and on the expected edge, which exposes an off-by-one in the match timing, and the idle channel is checked at the same time to catch crosstalk. Directed cases cover a shared match value on both channels, status writes of 0 and of 1, an attempted counter write, and a narrow-counter instance whose interval spans a wrap, which tells modular equality apart from a magnitude compare and pins the overflow edge.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

  // pin action on a match
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TOG  = 2'd3
  } pin_act_e;

  // register map (word addresses)
  localparam int ADDR_CNT    = 0;
  localparam int ADDR_CTRL   = 1;
  localparam int ADDR_STAT   = 2;
  localparam int ADDR_MATCH0 = 3;

  // control field per channel: enable + 2-bit action
  localparam int CTRL_FIELD_W = 3;

  function automatic logic next_pin(input pin_act_e act, input logic cur);
    case (act)
      ACT_SET:  return 1'b1;
      ACT_CLR:  return 1'b0;
      ACT_TOG:  return ~cur;
      default:  return cur;
    endcase
  endfunction

  function automatic logic next_flag(input logic hit, input logic clr, input logic cur);
    // a new event wins over a clear in the same cycle
    if (hit)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/tmr_free_cnt.sv
module tmr_free_cnt #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // the next edge takes the counter from all ones to zero
  assign wrap = (cnt == CNT_MAX);
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import tmr_cmp_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] match,
  input  logic         en,
  input  pin_act_e     act,
  input  logic         clr,
  output logic         hit,
  output logic         flag,
  output logic         pin
);
  assign hit = en && (cnt == match);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      pin  <= 1'b0;
    end else begin
      flag <= next_flag(hit, clr, flag);
      if (hit) pin <= next_pin(act, pin);
    end
  end
endmodule

// File: rtl/tmr_cmp_regs.sv
module tmr_cmp_regs
  import tmr_cmp_pkg::*;
#(
  parameter int W   = 24,
  parameter int NCH = 2,
  parameter int AW  = 3,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic [W-1:0]   cnt,
  input  logic           ovf_set,
  input  logic [NCH-1:0] ch_flag,
  output logic [NCH-1:0] ch_en,
  output pin_act_e       ch_act   [NCH],
  output logic [W-1:0]   ch_match [NCH],
  output logic [NCH-1:0] ch_clr,
  output logic           ovf_clr,
  output logic           ovf_flag
);
  localparam int CTRL_W = CTRL_FIELD_W * NCH;

  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_ctrl, wr_stat;
  logic              unused_wdata;

  assign wr_ctrl      = reg_wr && (reg_addr == AW'(ADDR_CTRL));
  assign wr_stat      = reg_wr && (reg_addr == AW'(ADDR_STAT));
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_en[i]  = ctrl_q[CTRL_FIELD_W*i];
    assign ch_act[i] = pin_act_e'(ctrl_q[CTRL_FIELD_W*i+1 +: 2]);
    assign ch_clr[i] = wr_stat && reg_wdata[i];

    always_ff @(posedge clk) begin
      if (rst)
        ch_match[i] <= '0;
      else if (reg_wr && (reg_addr == AW'(ADDR_MATCH0 + i)))
        ch_match[i] <= reg_wdata[W-1:0];
    end
  end

  assign ovf_clr = wr_stat && reg_wdata[NCH];

  always_ff @(posedge clk) begin
    if (rst) ovf_flag <= 1'b0;
    else     ovf_flag <= next_flag(ovf_set, ovf_clr, ovf_flag);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(ADDR_CNT))
      reg_rdata[W-1:0] = cnt;
    else if (reg_addr == AW'(ADDR_CTRL))
      reg_rdata[CTRL_W-1:0] = ctrl_q;
    else if (reg_addr == AW'(ADDR_STAT))
      reg_rdata[NCH:0] = {ovf_flag, ch_flag};
    else begin
      for (int i = 0; i < NCH; i++)
        if (reg_addr == AW'(ADDR_MATCH0 + i))
          reg_rdata[W-1:0] = ch_match[i];
    end
  end
endmodule

// File: rtl/tmr_cmp_top.sv
module tmr_cmp_top
  import tmr_cmp_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int NCH   = 2,
  parameter int AW    = 3,
  parameter int DW    = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic [NCH-1:0] irq_cmp,
  output logic           irq_ovf,
  output logic [NCH-1:0] cmp_pin
);
  // named internal events, observed by the bound checker
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_wrap;
  logic [NCH-1:0]   ch_hit, ch_flag, ch_en, ch_clr;
  logic             ovf_clr, ovf_flag;
  pin_act_e         ch_act   [NCH];
  logic [CNT_W-1:0] ch_match [NCH];

  tmr_free_cnt #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .cnt  (cnt_q),
    .wrap (cnt_wrap)
  );

  tmr_cmp_regs #(.W(CNT_W), .NCH(NCH), .AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cnt       (cnt_q),
    .ovf_set   (cnt_wrap),
    .ch_flag   (ch_flag),
    .ch_en     (ch_en),
    .ch_act    (ch_act),
    .ch_match  (ch_match),
    .ch_clr    (ch_clr),
    .ovf_clr   (ovf_clr),
    .ovf_flag  (ovf_flag)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    tmr_cmp_chan #(.W(CNT_W)) u_chan (
      .clk   (clk),
      .rst   (rst),
      .cnt   (cnt_q),
      .match (ch_match[i]),
      .en    (ch_en[i]),
      .act   (ch_act[i]),
      .clr   (ch_clr[i]),
      .hit   (ch_hit[i]),
      .flag  (ch_flag[i]),
      .pin   (cmp_pin[i])
    );
  end

  assign irq_cmp = ch_flag;
  assign irq_ovf = ovf_flag;
endmodule

// File: rtl/tmr_cmp_chk.sv
module tmr_cmp_chk #(
  parameter int CNT_W = 24,
  parameter int NCH   = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_wrap,
  input logic [NCH-1:0]   ch_hit,
  input logic [NCH-1:0]   ch_flag,
  input logic [NCH-1:0]   ch_en,
  input logic [NCH-1:0]   ch_clr,
  input logic [NCH-1:0]   ch_pin,
  input logic             ovf_flag,
  input logic             ovf_clr
);
  // R2: one step per clock
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R9: wrap edge raises overflow and lands on zero
  a_r9_ovf_on_wrap: assert property (@(posedge clk) disable iff (rst)
    cnt_wrap |=> (ovf_flag && cnt == '0));

  // R9: overflow flag holds until cleared
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R3: a match sets the flag on the next edge
    a_r3_hit_sets_flag: assert property (@(posedge clk) disable iff (rst)
      ch_hit[i] |=> ch_flag[i]);

    // R4: flag sticky without a clear
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (ch_flag[i] && !ch_clr[i]) |=> ch_flag[i]);

    // R4: clear without a new match drops the flag
    a_r4_flag_clear: assert property (@(posedge clk) disable iff (rst)
      (ch_clr[i] && !ch_hit[i]) |=> !ch_flag[i]);

    // R5: pin moves only after a match
    a_r5_pin_quiet: assert property (@(posedge clk) disable iff (rst)
      !ch_hit[i] |=> $stable(ch_pin[i]));

    // R6: a disabled, clear channel stays clear
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
      (!ch_en[i] && !ch_flag[i]) |=> !ch_flag[i]);
  end
endmodule

bind tmr_cmp_top tmr_cmp_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt      (cnt_q),
  .cnt_wrap (cnt_wrap),
  .ch_hit   (ch_hit),
  .ch_flag  (ch_flag),
  .ch_en    (ch_en),
  .ch_clr   (ch_clr),
  .ch_pin   (cmp_pin),
  .ovf_flag (ovf_flag),
  .ovf_clr  (ovf_clr)
);

// File: tb/tb_tmr_cmp_top.sv
`timescale 1ns/1ps
module tb_tmr_cmp_top;
  localparam int W  = 24;
  localparam int WS = 10;   // narrow instance for wrap tests
  localparam logic [31:0] MASK  = (32'd1 << W) - 1;
  localparam logic [31:0] MASKS = (32'd1 << WS) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rd_w;
  logic [1:0]  irq, irq_w, pin, pin_w;
  logic        ovf, ovf_w;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;   // 50 MHz

  tmr_cmp_top dut (
    .clk(clk), .rst(rst), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq_cmp(irq), .irq_ovf(ovf), .cmp_pin(pin)
  );

  tmr_cmp_top #(.CNT_W(WS)) dut_w (
    .clk(clk), .rst(rst), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rd_w), .irq_cmp(irq_w), .irq_ovf(ovf_w), .cmp_pin(pin_w)
  );

  // vector: {ch, en, act[1:0], exp_flag, exp_pin, 2'b0, delay[7:0]}
  function automatic logic [15:0] mkv(input bit ch, input bit en, input logic [1:0] act,
                                      input bit ef, input bit ep, input logic [7:0] d);
    return {ch, en, act, ef, ep, 2'b00, d};
  endfunction

  localparam logic [15:0] VEC [9] = '{
    mkv(1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 8'd5),
    mkv(1'b0, 1'b1, 2'd3, 1'b1, 1'b0, 8'd3),
    mkv(1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 8'd9),
    mkv(1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 8'd4),
    mkv(1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 8'd6),
    mkv(1'b1, 1'b0, 2'd2, 1'b0, 1'b1, 8'd5),
    mkv(1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 8'd7),
    mkv(1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 8'd2),
    mkv(1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 8'd2)
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge; returns at the following negedge
  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 3'd0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] c, c2, v;
    logic [1:0]  pm;
    pm = 2'b00;

    // R1: reset state
    repeat (3) @(negedge clk);
    rreg(3'd0, v); chk(v == 0, "R1 counter in reset", v, 0);
    chk({irq, ovf, pin} == 0, "R1 irq/pin in reset", {irq, ovf, pin}, 0);
    rst = 1'b0;
    @(negedge clk);
    rreg(3'd1, v); chk(v == 0, "R1 ctrl after reset", v, 0);

    // R2: counting and ignored write
    rreg(3'd0, c); @(negedge clk); rreg(3'd0, c2);
    chk(c2 == ((c + 1) & MASK), "R2 increment", c2, (c + 1) & MASK);
    wreg(3'd0, 32'h00ABCDEF); rreg(3'd0, v);
    chk(v == ((c2 + 1) & MASK), "R2 counter write ignored", v, (c2 + 1) & MASK);

    // table walk: R3 R5 R6 R7
    for (int k = 0; k < 9; k++) begin
      logic        ch, en, ef, ep, oth_pin;
      logic [1:0]  act;
      logic [7:0]  d;
      {ch, en, act, ef, ep} = VEC[k][15:10];
      d = VEC[k][7:0];
      wreg(3'd1, 32'({act, en}) << (3 * ch));
      wreg(3'd2, 32'h7);
      chk(irq == 0, "R4 flags cleared", irq, 0);
      oth_pin = pm[~ch];
      rreg(3'd0, c);
      wreg(3'd3 + 3'(ch), (c + d) & MASK);
      repeat (d - 1) @(negedge clk);
      chk(irq[ch] == 1'b0, "R3 no flag one cycle early", irq[ch], 0);
      chk(pin[ch] == pm[ch], "R5 pin holds before match", pin[ch], pm[ch]);
      @(negedge clk);
      chk(irq[ch] == ef, "R3/R6 flag on match edge", irq[ch], ef);
      chk(pin[ch] == ep, "R5/R6 pin after match", pin[ch], ep);
      chk(irq[~ch] == 1'b0 && pin[~ch] == oth_pin, "R7 other channel untouched",
          {irq[~ch], pin[~ch]}, {1'b0, oth_pin});
      pm[ch] = ep;
    end

    // R7: shared match value, both channels set
    wreg(3'd2, 32'h7);
    wreg(3'd1, 32'h1B);
    rreg(3'd0, c);
    wreg(3'd3, (c + 8) & MASK);
    wreg(3'd4, (c + 8) & MASK);
    repeat (6) @(negedge clk);
    chk(irq == 2'b00, "R7 both quiet before match", irq, 0);
    @(negedge clk);
    chk(irq == 2'b11, "R7 both fire together", irq, 3);
    chk(pin == 2'b11, "R5 both pins set", pin, 3);

    // R4: write-0 keeps, write-1 clears one bit
    wreg(3'd2, 32'h0);
    chk(irq == 2'b11, "R4 zero write keeps flags", irq, 3);
    wreg(3'd2, 32'h1);
    chk(irq == 2'b10, "R4 clear channel 0 only", irq, 2);
    rreg(3'd2, v);
    chk(v[1:0] == 2'b10, "R4 status read", v, 2);

    // R8 R9: wrap on the narrow instance
    wreg(3'd1, 32'h3);
    wreg(3'd3, 32'h200);
    for (int i = 0; i < 1100; i++) begin
      rreg(3'd0, v); v = rd_w;
      if (v == 1000) break;
      @(negedge clk);
    end
    wreg(3'd2, 32'h7);
    for (int i = 0; i < 40; i++) begin
      rreg(3'd0, v); v = rd_w;
      if (v == 1020) break;
      @(negedge clk);
    end
    chk(v == 1020 && ovf_w == 1'b0, "R9 positioned before wrap", {v[30:0], ovf_w}, {31'd1020, 1'b0});
    wreg(3'd3, (32'd1020 + 32'd40) & MASKS);
    repeat (2) @(negedge clk);
    chk(ovf_w == 1'b0, "R9 no overflow before wrap edge", ovf_w, 0);
    @(negedge clk);
    chk(ovf_w == 1'b1, "R9 overflow on wrap edge", ovf_w, 1);
    chk(irq_w == 2'b00, "R9 overflow on its own line", irq_w, 0);
    repeat (36) @(negedge clk);
    chk(irq_w[0] == 1'b0, "R8 wrapped match not early", irq_w[0], 0);
    @(negedge clk);
    chk(irq_w[0] == 1'b1 && pin_w[0] == 1'b1, "R8 wrapped match fires", {irq_w[0], pin_w[0]}, 2'b11);
    wreg(3'd2, 32'h4);
    chk(ovf_w == 1'b0 && irq_w[0] == 1'b1, "R9 overflow clear only", {ovf_w, irq_w[0]}, 2'b01);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule